// File: doc/BRIEF.md
# Post-Multiplier Accumulator with Rounding Preload and Cascade Adder

This block is the adder stage that sits behind a fixed-point multiplier in an arithmetic column. On each enabled clock it takes a signed product, sign-extends it to 64 bits and combines it with one other operand. That operand is zero, a one-hot rounding constant, the stage's own previous result, or the cascade value arriving from the stage upstream. Three dynamic control bits pick the operand and whether the product is negated first: negate, load-constant and accumulate. A fourth bit removes the cascade value from the sum.

Data and the three function bits are captured in an input register that honours the clock enable. The cascade-disable bit has its own input register, which loads on every clock. The sum is then stored in a 64-bit result register, and that register also drives the cascade output toward the next stage. All arithmetic wraps modulo 2^64.

Top module: `pma_top`

## Requirements
- R1: A synchronous active-high reset clears the input registers and the result register, so `result_o` and `cascade_o` read 0 after the reset edge.
- R2: Inputs sampled at a clock edge with `ce_i` high appear on `result_o` after the following edge, which is two edges of latency.
- R3: With negate=0, load-constant=0, accumulate=0, the result is the product sign-extended from `IN_W` bits to 64 bits.
- R4: With negate=0, load-constant=1, accumulate=0, the result is the sign-extended product plus `round_i`, and `round_i` must have exactly one bit set.
- R5: With negate=0 and accumulate=1, the result is the previous result plus the sign-extended product, whatever load-constant is.
- R6: With negate=1 and accumulate=1, the result is the previous result minus the sign-extended product, whatever load-constant is.
- R7: With negate=1, load-constant=0, accumulate=0, the result is `cascade_i` minus the sign-extended product.
- R8: When the registered cascade-disable bit is 1, the cascade term of R7 is replaced by 0. That register loads on every clock edge, even while `ce_i` is low.
- R9: The combination negate=1, load-constant=1, accumulate=0 behaves exactly like the R3 case.
- R10: While `ce_i` is low, the result register and the data and function input registers hold their values.
- R11: Sums that overflow 64 bits wrap modulo 2^64.
- R12: `cascade_o` always equals `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Clock enable for the data path registers |
| neg_i | input | 1 | Negate the product |
| ldc_i | input | 1 | Select the rounding constant as the addend |
| acc_i | input | 1 | Feed the previous result back |
| nocasc_i | input | 1 | Remove the cascade input from the sum |
| prod_i | input | IN_W | Signed product from the multiplier |
| cascade_i | input | ACC_W | Cascade value from the upstream stage |
| round_i | input | ACC_W | One-hot rounding constant |
| result_o | output | ACC_W | Registered result |
| cascade_o | output | ACC_W | Cascade output to the downstream stage (same as result) |

## Verification
Two effects can meet in the same cycle: a clock enable held low, which freezes the operands and the result, and a change of the cascade-disable bit, whose input register keeps loading regardless. The bench provokes this by capturing a negate-and-cascade operation and then dropping the enable for one edge while raising the disable bit. It then restores the enable. The result is judged against the product negated alone. A design that gated the disable register with the enable would instead still include the cascade value.

// File: rtl/pma_pkg.sv
package pma_pkg;
  typedef enum logic [2:0] {
    MODE_ZERO,
    MODE_PRELOAD,
    MODE_ACCUM,
    MODE_NEGACC,
    MODE_NEGCASC
  } mode_e;
endpackage

// File: rtl/pma_mode_dec.sv
module pma_mode_dec (
  input  logic           neg_i,
  input  logic           ldc_i,
  input  logic           acc_i,
  output pma_pkg::mode_e mode_o
);
  import pma_pkg::*;

  always_comb begin
    if (acc_i && neg_i)             mode_o = MODE_NEGACC;
    else if (acc_i)                 mode_o = MODE_ACCUM;
    else if (neg_i && !ldc_i)       mode_o = MODE_NEGCASC;
    else if (!neg_i && ldc_i)       mode_o = MODE_PRELOAD;
    else                            mode_o = MODE_ZERO;   // includes neg=1, ldc=1 (R9)
  end
endmodule

// File: rtl/pma_in_stage.sv
module pma_in_stage #(
  parameter int IN_W  = 32,
  parameter int ACC_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_i,
  input  pma_pkg::mode_e    mode_i,
  input  logic [IN_W-1:0]   prod_i,
  input  logic [ACC_W-1:0]  casc_i,
  input  logic [ACC_W-1:0]  round_i,
  input  logic              nocasc_i,
  output pma_pkg::mode_e    mode_q,
  output logic [IN_W-1:0]   prod_q,
  output logic [ACC_W-1:0]  casc_q,
  output logic [ACC_W-1:0]  round_q,
  output logic              nocasc_q
);
  import pma_pkg::*;

  // Data and function bits: gated by the clock enable
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_ZERO;
      prod_q  <= '0;
      casc_q  <= '0;
      round_q <= '0;
    end else if (ce_i) begin
      mode_q  <= mode_i;
      prod_q  <= prod_i;
      casc_q  <= casc_i;
      round_q <= round_i;
    end
  end

  // Cascade-disable bit: loads on every clock
  always_ff @(posedge clk) begin
    if (rst) nocasc_q <= 1'b0;
    else     nocasc_q <= nocasc_i;
  end

  assert_nocasc_free_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nocasc_q == $past(nocasc_i)));

  assert_round_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    (ce_i && mode_i == MODE_PRELOAD) |-> $onehot(round_i));

  assert_hold_inputs_R10: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> ($stable(prod_q) && $stable(casc_q) && $stable(mode_q)));
endmodule

// File: rtl/pma_sum_core.sv
module pma_sum_core #(
  parameter int IN_W  = 32,
  parameter int ACC_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_i,
  input  pma_pkg::mode_e    mode_i,
  input  logic [IN_W-1:0]   prod_i,
  input  logic [ACC_W-1:0]  casc_i,
  input  logic [ACC_W-1:0]  round_i,
  input  logic              nocasc_i,
  output logic [ACC_W-1:0]  acc_q
);
  import pma_pkg::*;

  localparam int EXT_W = ACC_W - IN_W;

  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] sum;
  logic             negate;

  generate
    if (EXT_W > 0) begin : g_ext
      assign prod_ext = {{EXT_W{prod_i[IN_W-1]}}, prod_i};
    end else begin : g_trunc
      assign prod_ext = prod_i[ACC_W-1:0];
    end
  endgenerate

  assign negate = (mode_i == MODE_NEGACC) || (mode_i == MODE_NEGCASC);
  assign addend = negate ? (~prod_ext + 1'b1) : prod_ext;

  always_comb begin
    unique case (mode_i)
      MODE_PRELOAD:             base = round_i;
      MODE_ACCUM, MODE_NEGACC:  base = acc_q;
      MODE_NEGCASC:             base = nocasc_i ? '0 : casc_i;
      default:                  base = '0;
    endcase
  end

  assign sum = base + addend;   // wraps modulo 2^ACC_W

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (ce_i) acc_q <= sum;
  end

  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_clear_R1: assert (acc_q == '0)
        else $error("result not cleared by reset");
    end
  end

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> $stable(acc_q));

  assert_accum_R5: assert property (@(posedge clk) disable iff (rst)
    (ce_i && mode_i == MODE_ACCUM) |=> (acc_q == $past(acc_q) + $past(prod_ext)));

  assert_negacc_R6: assert property (@(posedge clk) disable iff (rst)
    (ce_i && mode_i == MODE_NEGACC) |=> (acc_q == $past(acc_q) - $past(prod_ext)));
endmodule

// File: rtl/pma_top.sv
module pma_top #(
  parameter int IN_W  = 32,
  parameter int ACC_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_i,
  input  logic              neg_i,
  input  logic              ldc_i,
  input  logic              acc_i,
  input  logic              nocasc_i,
  input  logic [IN_W-1:0]   prod_i,
  input  logic [ACC_W-1:0]  cascade_i,
  input  logic [ACC_W-1:0]  round_i,
  output logic [ACC_W-1:0]  result_o,
  output logic [ACC_W-1:0]  cascade_o
);
  import pma_pkg::*;

  mode_e            mode_raw;
  mode_e            mode_q;
  logic [IN_W-1:0]  prod_q;
  logic [ACC_W-1:0] casc_q;
  logic [ACC_W-1:0] round_q;
  logic             nocasc_q;
  logic [ACC_W-1:0] acc_q;

  pma_mode_dec u_dec (
    .neg_i  (neg_i),
    .ldc_i  (ldc_i),
    .acc_i  (acc_i),
    .mode_o (mode_raw)
  );

  pma_in_stage #(.IN_W(IN_W), .ACC_W(ACC_W)) u_in (
    .clk      (clk),
    .rst      (rst),
    .ce_i     (ce_i),
    .mode_i   (mode_raw),
    .prod_i   (prod_i),
    .casc_i   (cascade_i),
    .round_i  (round_i),
    .nocasc_i (nocasc_i),
    .mode_q   (mode_q),
    .prod_q   (prod_q),
    .casc_q   (casc_q),
    .round_q  (round_q),
    .nocasc_q (nocasc_q)
  );

  pma_sum_core #(.IN_W(IN_W), .ACC_W(ACC_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .ce_i     (ce_i),
    .mode_i   (mode_q),
    .prod_i   (prod_q),
    .casc_i   (casc_q),
    .round_i  (round_q),
    .nocasc_i (nocasc_q),
    .acc_q    (acc_q)
  );

  assign result_o  = acc_q;
  assign cascade_o = acc_q;   // R12
endmodule

// File: tb/pma_top_tb_top.sv
module pma_top_tb_top;
  localparam int IN_W  = 32;
  localparam int ACC_W = 64;
  localparam int NV    = 12;

  typedef struct packed {
    logic [3:0]       req;
    logic             neg;
    logic             ldc;
    logic             acc;
    logic             noc;
    logic [IN_W-1:0]  p;
    logic [ACC_W-1:0] casc;
    logic [ACC_W-1:0] rnd;
    logic [ACC_W-1:0] exp;
  } vec_t;

  // Each expected value follows from the requirements, applied in order.
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b0,1'b0,1'b0,1'b0, 32'd5,          64'd0,    64'd0,      64'd5},                   // R3
    '{4'd5,  1'b0,1'b0,1'b1,1'b0, 32'd7,          64'd0,    64'd0,      64'd12},                  // R5
    '{4'd5,  1'b0,1'b1,1'b1,1'b0, 32'hFFFF_FFFD,  64'd0,    64'd0,      64'd9},                   // R5 ldc ignored
    '{4'd6,  1'b1,1'b0,1'b1,1'b0, 32'd4,          64'd0,    64'd0,      64'd5},                   // R6
    '{4'd6,  1'b1,1'b1,1'b1,1'b0, 32'd10,         64'd0,    64'd0,      64'hFFFF_FFFF_FFFF_FFFB}, // R6
    '{4'd4,  1'b0,1'b1,1'b0,1'b0, 32'd100,        64'd0,    64'd256,    64'd356},                 // R4
    '{4'd7,  1'b1,1'b0,1'b0,1'b0, 32'd3,          64'd1000, 64'd0,      64'd997},                 // R7
    '{4'd8,  1'b1,1'b0,1'b0,1'b1, 32'd3,          64'd1000, 64'd0,      64'hFFFF_FFFF_FFFF_FFFD}, // R8
    '{4'd9,  1'b1,1'b1,1'b0,1'b0, 32'hFFFF_FFF8,  64'd0,    64'd0,      64'hFFFF_FFFF_FFFF_FFF8}, // R9
    '{4'd3,  1'b0,1'b0,1'b0,1'b0, 32'h8000_0000,  64'd0,    64'd0,      64'hFFFF_FFFF_8000_0000}, // R3 sign extension
    '{4'd11, 1'b0,1'b1,1'b0,1'b0, 32'hFFFF_FFFF,  64'd0,    64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, // R11
    '{4'd11, 1'b0,1'b0,1'b1,1'b0, 32'd1,          64'd0,    64'd0,      64'h8000_0000_0000_0000}  // R11
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             ce_i;
  logic             neg_i, ldc_i, acc_i, nocasc_i;
  logic [IN_W-1:0]  prod_i;
  logic [ACC_W-1:0] cascade_i, round_i;
  logic [ACC_W-1:0] result_o, cascade_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pma_top #(.IN_W(IN_W), .ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst(rst), .ce_i(ce_i),
    .neg_i(neg_i), .ldc_i(ldc_i), .acc_i(acc_i), .nocasc_i(nocasc_i),
    .prod_i(prod_i), .cascade_i(cascade_i), .round_i(round_i),
    .result_o(result_o), .cascade_o(cascade_o)
  );

  task automatic chk(input int req, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic n, input logic l, input logic a, input logic nc,
                       input logic [IN_W-1:0] p, input logic [ACC_W-1:0] c,
                       input logic [ACC_W-1:0] r);
    neg_i = n; ldc_i = l; acc_i = a; nocasc_i = nc;
    prod_i = p; cascade_i = c; round_i = r;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; ce_i = 1'b1;
    drive(0,0,0,0, '0, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(1, result_o, 64'd0);            // R1 reset state
    chk(12, cascade_o, 64'd0);          // R12
    rst = 1'b0;

    // Table walk, two edges of latency
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk(int'(VECS[i-2].req), result_o, VECS[i-2].exp);
        chk(12, cascade_o, result_o);   // R12
      end
      if (i < NV)
        drive(VECS[i].neg, VECS[i].ldc, VECS[i].acc, VECS[i].noc,
              VECS[i].p, VECS[i].casc, VECS[i].rnd);
      else
        drive(0,0,0,0, '0, '0, '0);
      step();
    end

    // R10: enable low, accumulate request held off
    drive(0,0,1,0, 32'd50, '0, '0);
    step();                              // zero mode result from the idle vector
    chk(3, result_o, 64'd0);
    ce_i = 1'b0;
    drive(0,0,1,0, 32'd77, '0, '0);
    step(); step(); step();
    chk(10, result_o, 64'd0);            // R10 hold
    ce_i = 1'b1;
    drive(0,0,0,0, '0, '0, '0);
    step();                              // core sees held accumulate of 50
    chk(10, result_o, 64'd50);           // R10 held operand kept

    // R8: disable bit loads while enable is low
    drive(1,0,0,0, 32'd3, 64'd1000, '0);
    step();                              // captured
    ce_i = 1'b0;
    drive(1,0,0,1, 32'd3, 64'd1000, '0);
    step();                              // only disable register moves
    ce_i = 1'b1;
    drive(0,0,0,1, '0, '0, '0);
    step();
    chk(8, result_o, 64'hFFFF_FFFF_FFFF_FFFD);   // R8 coincides with R10

    // R1: reset in mid-run
    drive(0,0,0,0, 32'd9, '0, '0);
    step(); step();
    chk(3, result_o, 64'd9);
    rst = 1'b1;
    step();
    chk(1, result_o, 64'd0);             // R1
    chk(12, cascade_o, 64'd0);           // R1, R12
    rst = 1'b0;

    // R2: latency of exactly two edges
    drive(0,0,0,0, 32'd77, '0, '0);
    step();
    drive(0,0,0,0, '0, '0, '0);
    chk(2, result_o, 64'd0);             // R2 not yet visible
    step();
    chk(2, result_o, 64'd77);            // R2 visible

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule